// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It holds the program counter, a 32-entry by 32-bit register file with two read ports and one write port, a 16-to-32-bit sign extender, an arithmetic/logic unit, the write-back selection and a decoder in two levels. The first level maps the 6-bit opcode to datapath steering and a 2-bit operation class. The second level turns that class, and for register-register instructions the funct field, into a 4-bit ALU code.

Instruction memory is read combinationally: the core presents the current PC and receives the instruction word in the same cycle. Data memory is reached through an address, a write-data bus, a read-data bus, a read strobe and a write strobe. Load data must come back combinationally within the cycle. Stores are committed by the memory on the rising edge while the write strobe is high. The supported operations are add, subtract, and, or, set-less-than, add-immediate, load word, store word, branch-if-equal and jump.

Top module: `unicycle_core`

## Requirements
- R1: `rst` is synchronous and active high. The rising edge with `rst` high sets the PC (`imem_addr`) to 0. While `rst` is high, no data read strobe, data write strobe or register write is issued.
- R2: An instruction that is not a taken branch and not a jump moves the PC to PC+4 at the next rising edge.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm16 [15:0] and target [25:0]. Opcode 0 is register-register and writes rd. Funct 0x20 is add, 0x22 is subtract, 0x24 is and, and 0x25 is or.
- R4: Funct 0x2A is set-less-than. It writes 1 to rd when R[rs] < R[rt] as signed two's-complement values, and 0 otherwise.
- R5: Opcode 8 (add-immediate) writes R[rs] plus the sign-extended imm16 into rt.
- R6: Opcode 35 (load word) drives `dmem_addr` = R[rs] + sign-extended imm16 and raises `dmem_rd`. It writes `dmem_rdata` into rt.
- R7: Opcode 43 (store word) drives `dmem_addr` = R[rs] + sign-extended imm16 and `dmem_wdata` = R[rt]. It raises `dmem_wr` and writes no register.
- R8: Opcode 4 (branch-if-equal) sets the next PC to PC+4 + (sign-extended imm16 shifted left by 2) when R[rs] = R[rt], and to PC+4 otherwise. Negative offsets branch backwards.
- R9: Opcode 2 (jump) sets the next PC to {bits [31:28] of PC+4, target, 2'b00}.
- R10: Register 0 always reads as zero, and a write to it leaves it zero.
- R11: An opcode outside {0, 2, 4, 8, 35, 43}, or a register-register funct outside the five listed, changes no register and raises no data strobe, and the PC advances by 4.
- R12: `dmem_rd` is high only for a load and `dmem_wr` only for a store, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Current PC, byte address of the instruction to fetch |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Data byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |
| dmem_rd | output | 1 | Read strobe, high during a load |
| dmem_wr | output | 1 | Write strobe, high during a store |

## Verification
Almost all state in this core is hidden inside the register file, so a wrong register value cannot be seen until a later store drives it onto `dmem_wdata`, or a later branch compares it and steers `imem_addr`. Each result is therefore stored or compared a few instructions after it is produced. A wrong destination index, a lost write to register 0 or a wrong sign extension then appears as a miscompare within two to four cycles. A wrong PC, whether from a branch offset, a jump concatenation or a missing +4, shows on `imem_addr` at the very next cycle. Illegal encodings are placed before stores of the registers they name, so that a spurious write would be exposed.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;
  localparam int OP_W   = 6;

  localparam logic [OP_W-1:0] OP_REG  = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP  = 6'd2;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'd4;
  localparam logic [OP_W-1:0] OP_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OP_LD   = 6'd35;
  localparam logic [OP_W-1:0] OP_ST   = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_ctl_e;

  typedef enum logic [1:0] {
    CLS_ADD = 2'b00,
    CLS_SUB = 2'b01,
    CLS_FN  = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_wr;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_ctl_e ctl,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] br_target(input logic [XLEN-1:0] seq,
                                                input logic [15:0] imm);
    return seq + {sext16(imm)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jmp_target(input logic [XLEN-1:0] seq,
                                                 input logic [25:0] tgt);
    return {seq[XLEN-1:28], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/uc_decode.sv
module uc_decode
  import uc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl,
  output alu_ctl_e        alu_ctl,
  output logic            legal
);
  logic [OP_W-1:0] op;
  logic [5:0]      fn;
  logic            op_ok;
  logic            fn_ok;

  assign op = instr[31:26];
  assign fn = instr[5:0];

  // level 1: opcode -> steering and operation class
  always_comb begin
    ctrl  = '0;
    op_ok = 1'b1;
    case (op)
      OP_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        ctrl.cls    = CLS_FN;
      end
      OP_LD: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_ST: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_SUB;
      end
      OP_ADDI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_JMP:  ctrl.jump = 1'b1;
      default: op_ok = 1'b0;
    endcase
  end

  // level 2: class (+ funct) -> ALU code
  always_comb begin
    fn_ok   = 1'b1;
    alu_ctl = ALU_ADD;
    case (ctrl.cls)
      CLS_ADD: alu_ctl = ALU_ADD;
      CLS_SUB: alu_ctl = ALU_SUB;
      default: begin
        case (fn)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
    endcase
  end

  assign legal = op_ok && ((ctrl.cls != CLS_FN) || fn_ok);
endmodule

// File: rtl/uc_regfile.sv
module uc_regfile #(
  parameter int W      = 32,
  parameter int IDX_W  = 5,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  output logic [W-1:0]     rd_a,
  output logic [W-1:0]     rd_b
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) cells[waddr] <= wdata;
  end

  assign rd_a = (ra_a == '0) ? '0 : cells[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : cells[ra_b];
endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_pkg::*;
(
  input  alu_ctl_e        ctl,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(ctl, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/unicycle_core.sv
module unicycle_core
  import uc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            dmem_rd,
  output logic            dmem_wr
);
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_seq;
  logic [XLEN-1:0]   next_pc;
  logic [RIDX_W-1:0] rs_idx;
  logic [RIDX_W-1:0] rt_idx;
  logic [RIDX_W-1:0] rd_idx;
  logic [RIDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   imm_x;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic [XLEN-1:0]   rf_wdata;
  logic              alu_zero;
  logic              legal;
  logic              rf_we;
  logic              take_branch;
  logic              is_jump;
  ctrl_t             ctrl;
  alu_ctl_e          alu_ctl;

  assign rs_idx = imem_data[25:21];
  assign rt_idx = imem_data[20:16];
  assign rd_idx = imem_data[15:11];
  assign imm_x  = sext16(imem_data[15:0]);

  uc_decode u_dec (
    .instr   (imem_data),
    .ctrl    (ctrl),
    .alu_ctl (alu_ctl),
    .legal   (legal)
  );

  uc_regfile #(.W(XLEN), .IDX_W(RIDX_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra_a  (rs_idx),
    .ra_b  (rt_idx),
    .rd_a  (rs_val),
    .rd_b  (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_x : rt_val;

  uc_alu u_alu (
    .ctl  (alu_ctl),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // write-back
  assign rf_waddr = ctrl.dst_rd ? rd_idx : rt_idx;
  assign rf_wdata = ctrl.wb_mem ? dmem_rdata : alu_y;
  assign rf_we    = ctrl.reg_wr && legal && !rst;

  // data port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_rd    = ctrl.mem_rd && legal && !rst;
  assign dmem_wr    = ctrl.mem_wr && legal && !rst;

  // next PC
  assign pc_seq      = pc_q + XLEN'(4);
  assign take_branch = ctrl.branch && legal && alu_zero;
  assign is_jump     = ctrl.jump && legal;

  always_comb begin
    if (is_jump)          next_pc = jmp_target(pc_seq, imem_data[25:0]);
    else if (take_branch) next_pc = br_target(pc_seq, imem_data[15:0]);
    else                  next_pc = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/uc_core_checks.sv
module uc_core_checks (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  opcode,
  input logic [25:0] target,
  input logic        dmem_rd,
  input logic        dmem_wr,
  input logic        rf_we,
  input logic        legal,
  input logic        take_branch,
  input logic        is_jump,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val
);
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  a_r1_quiet_reset: assert property (@(posedge clk)
    rst |-> (!dmem_wr && !dmem_rd && !rf_we));

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !is_jump) |=> (pc == $past(pc) + 32'd4));

  a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> (opcode == 6'd43));

  a_r8_branch_only: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> (opcode == 6'd4));

  a_r9_jump_low: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> (pc[27:0] == {$past(target), 2'b00}));

  a_r10_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0));

  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    !legal |-> (!dmem_wr && !dmem_rd && !rf_we));

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));
endmodule

bind unicycle_core uc_core_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .pc          (imem_addr),
  .opcode      (imem_data[31:26]),
  .target      (imem_data[25:0]),
  .dmem_rd     (dmem_rd),
  .dmem_wr     (dmem_wr),
  .rf_we       (rf_we),
  .legal       (legal),
  .take_branch (take_branch),
  .is_jump     (is_jump),
  .rs_idx      (rs_idx),
  .rs_val      (rs_val)
);

// File: tb/unicycle_core_test.sv
module unicycle_core_test;
  localparam int PERIOD = 10;
  localparam int NV     = 28;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] pc;
    logic        rd;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  // per step: instruction, expected PC, rd strobe, wr strobe, address, store data, requirement
  localparam vec_t VECS [NV] = '{
    '{enc_i(6'd8, 0, 1, 16'd5),      32'd0,   1'b0, 1'b0, 32'd0,  32'd0,        8'd5},  // R5 r1=5
    '{enc_i(6'd8, 0, 2, 16'hFFFD),   32'd4,   1'b0, 1'b0, 32'd0,  32'd0,        8'd5},  // R5 r2=-3
    '{enc_r(1, 2, 3, 6'h20),         32'd8,   1'b0, 1'b0, 32'd0,  32'd0,        8'd3},  // R3 add
    '{enc_i(6'd43, 0, 3, 16'd0),     32'd12,  1'b0, 1'b1, 32'd0,  32'd2,        8'd3},  // R3 sum=2
    '{enc_r(1, 2, 4, 6'h22),         32'd16,  1'b0, 1'b0, 32'd0,  32'd0,        8'd3},  // R3 sub
    '{enc_i(6'd43, 0, 4, 16'd4),     32'd20,  1'b0, 1'b1, 32'd4,  32'd8,        8'd3},  // R3 diff=8
    '{enc_r(1, 2, 5, 6'h24),         32'd24,  1'b0, 1'b0, 32'd0,  32'd0,        8'd3},  // R3 and
    '{enc_r(1, 2, 6, 6'h25),         32'd28,  1'b0, 1'b0, 32'd0,  32'd0,        8'd3},  // R3 or
    '{enc_i(6'd43, 0, 5, 16'd8),     32'd32,  1'b0, 1'b1, 32'd8,  32'd5,        8'd3},  // R3 and=5
    '{enc_i(6'd43, 0, 6, 16'd12),    32'd36,  1'b0, 1'b1, 32'd12, 32'hFFFFFFFD, 8'd3},  // R3 or
    '{enc_r(2, 1, 7, 6'h2A),         32'd40,  1'b0, 1'b0, 32'd0,  32'd0,        8'd4},  // R4 -3<5
    '{enc_r(1, 2, 8, 6'h2A),         32'd44,  1'b0, 1'b0, 32'd0,  32'd0,        8'd4},  // R4 5<-3
    '{enc_i(6'd43, 0, 7, 16'd16),    32'd48,  1'b0, 1'b1, 32'd16, 32'd1,        8'd4},  // R4 true
    '{enc_i(6'd43, 0, 8, 16'd20),    32'd52,  1'b0, 1'b1, 32'd20, 32'd0,        8'd4},  // R4 false
    '{enc_i(6'd35, 0, 9, 16'd12),    32'd56,  1'b1, 1'b0, 32'd12, 32'd0,        8'd6},  // R6 load
    '{enc_i(6'd8, 0, 10, 16'd40),    32'd60,  1'b0, 1'b0, 32'd0,  32'd0,        8'd5},  // R5 r10=40
    '{enc_i(6'd43, 10, 9, 16'hFFF8), 32'd64,  1'b0, 1'b1, 32'd32, 32'hFFFFFFFD, 8'd7},  // R7 neg offset
    '{enc_i(6'd4, 1, 1, 16'd2),      32'd68,  1'b0, 1'b0, 32'd0,  32'd0,        8'd8},  // R8 taken
    '{enc_i(6'd4, 1, 2, 16'd5),      32'd80,  1'b0, 1'b0, 32'd0,  32'd0,        8'd8},  // R8 not taken
    '{enc_i(6'd8, 0, 0, 16'd7),      32'd84,  1'b0, 1'b0, 32'd0,  32'd0,        8'd10}, // R10 write r0
    '{enc_i(6'd43, 0, 0, 16'd36),    32'd88,  1'b0, 1'b1, 32'd36, 32'd0,        8'd10}, // R10 r0 stays 0
    '{enc_j(26'd30),                 32'd92,  1'b0, 1'b0, 32'd0,  32'd0,        8'd9},  // R9 jump
    '{{6'h3F, 5'd1, 5'd1, 16'h1234}, 32'd120, 1'b0, 1'b0, 32'd0,  32'd0,        8'd11}, // R11 bad opcode
    '{enc_r(2, 2, 1, 6'h00),         32'd124, 1'b0, 1'b0, 32'd0,  32'd0,        8'd11}, // R11 bad funct
    '{enc_i(6'd43, 0, 1, 16'd40),    32'd128, 1'b0, 1'b1, 32'd40, 32'd5,        8'd11}, // R11 r1 intact
    '{enc_i(6'd4, 0, 0, 16'hFFEC),   32'd132, 1'b0, 1'b0, 32'd0,  32'd0,        8'd8},  // R8 backward
    '{enc_i(6'd43, 0, 1, 16'd44),    32'd56,  1'b0, 1'b1, 32'd44, 32'd5,        8'd2},  // R2 after branch
    '{enc_i(6'd43, 0, 2, 16'd48),    32'd60,  1'b0, 1'b1, 32'd48, 32'hFFFFFFFD, 8'd12}  // R12 store only
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_data = 32'd0;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic [31:0] dmem_rdata;
  logic        dmem_rd;
  logic        dmem_wr;
  logic [31:0] dmem [64];
  int          checks = 0;
  int          fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  unicycle_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr)
  );

  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'd0;
    repeat (2) @(posedge clk);
    #1;
    // R1: PC cleared and strobes quiet during reset
    check("R1", "pc in reset", imem_addr, 32'd0);
    check("R1", "wr in reset", {31'd0, dmem_wr}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      imem_data = VECS[i].ins;
      #1;
      check(tag, "pc", imem_addr, VECS[i].pc);
      check(tag, "rd strobe", {31'd0, dmem_rd}, {31'd0, VECS[i].rd});
      check(tag, "wr strobe", {31'd0, dmem_wr}, {31'd0, VECS[i].wr});
      if (VECS[i].rd || VECS[i].wr) check(tag, "addr", dmem_addr, VECS[i].addr);
      if (VECS[i].wr) check(tag, "wdata", dmem_wdata, VECS[i].wdata);
      @(negedge clk);
    end

    // R6: the loaded word landed in memory through the later store
    check("R6", "mem[32]", dmem[8], 32'hFFFFFFFD);

    // R1: reset mid-run with a store presented, then restart at 0
    imem_data = enc_i(6'd43, 0, 1, 16'd0);
    rst = 1'b1;
    #1;
    check("R1", "wr masked", {31'd0, dmem_wr}, 32'd0);
    @(negedge clk);
    check("R1", "pc after reset", imem_addr, 32'd0);
    check("R1", "mem[0] kept", dmem[0], 32'd2);
    rst = 1'b0;
    imem_data = enc_i(6'd8, 0, 11, 16'd1);
    @(negedge clk);
    check("R2", "pc after restart", imem_addr, 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule